// File: doc/BRIEF.md
# I2C Write-Only Tuner Register Interface

This block is an I2C slave that receives the programming words for a PLL frequency synthesizer. SCL and SDA arrive already synchronised to the system clock. The block watches them for START and STOP conditions and shifts in each byte on the rising edge of SCL. It acknowledges accepted bytes by asserting an open-drain pull-down enable during the ninth clock.

A write has three parts. It opens with a chip-address byte, and one bit of that byte must match the level of an external select pin, so two devices can share one bus. A subaddress byte follows and selects one of two byte groups. The data bytes of that group come last.

- The reference group carries a control byte followed by the 16-bit reference divide value, high byte first.
- The loop group carries the 16-bit loop divide value, high byte first.

Received bytes first go into shadow storage. A group reaches the active outputs only on a STOP that follows a complete group, so an interrupted write never disturbs the dividers. The control byte is decoded into the band select, the charge-pump current select and five switching-port bits.

The byte engine is a single state machine with these states:

| State | Role |
|---|---|
| `ST_IDLE` | Bus free |
| `ST_ADDR` | Shifting in the chip-address byte |
| `ST_ADDR_ACK` | Driving the address acknowledge |
| `ST_SUB` | Shifting in the subaddress byte |
| `ST_SUB_ACK` | Driving the subaddress acknowledge |
| `ST_DATA` | Shifting in a data byte |
| `ST_DATA_ACK` | Driving the data acknowledge |
| `ST_SKIP` | Transfer not addressed to this device; waiting for the bus to be released |

Its transitions are:

| Transition | Condition |
|---|---|
| any state → `ST_ADDR` | A START or repeated START is seen. |
| any state → `ST_IDLE` | A STOP is seen. |
| `ST_ADDR` → `ST_ADDR_ACK` | The SCL fall after the eighth bit, when the address matches. |
| `ST_ADDR` → `ST_SKIP` | The same SCL fall, when the address does not match. |
| `ST_SUB` → `ST_SUB_ACK` | The SCL fall after the eighth bit. The group is latched at this point. |
| `ST_DATA` → `ST_DATA_ACK` | The SCL fall after the eighth bit. The byte is written to shadow storage at this point. |
| each `*_ACK` state → next shifting state | The next SCL fall. `ST_ADDR_ACK` goes to `ST_SUB`; `ST_SUB_ACK` and `ST_DATA_ACK` go to `ST_DATA`. |

Top module: `tuner_i2c_regs`

## Requirements
- R1: After reset, the two divide outputs, the control byte and all decoded control bits are zero, and `sda_oe_o` is low.
- R2: An address byte is accepted and acknowledged when bits [7:2] equal `DEV_ADDR_HI` (default 6'b110001), bit 1 equals `addr_sel_i` and bit 0 (the read flag) is 0. With the default, this is 0xC4 for select low and 0xC6 for select high.
- R3: An address byte that fails R2 in any bit, including a set read flag, is not acknowledged. No byte of that transfer is acknowledged, and no output changes.
- R4: After subaddress `SUB_R` (default 0x00), the data bytes are, in order, the control byte, the reference divide high byte and the reference divide low byte.
- R5: After subaddress `SUB_N` (default 0x01), the data bytes are, in order, the loop divide high byte and the loop divide low byte.
- R6: A group's values reach the outputs only on a STOP that follows all bytes of that group. A shorter transfer changes nothing, and a write to one group leaves the other group's outputs unchanged.
- R7: Any other subaddress value is acknowledged, and so are its data bytes, but those bytes change no output.
- R8: Data bytes beyond the end of the selected group are acknowledged and ignored.
- R9: A repeated START discards every byte gathered since the previous START and begins a new address phase.
- R10: `band_fm_o` is control bit 0, `cp_fast_o` is control bit 1, and `sw_port_o[4:0]` is control bits 6 down to 2. `status_o` shows the whole control byte.
- R11: The acknowledge pull-down rises and falls only while SCL is low. It is released in the cycle after a START or a STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 20 times the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronised bus clock |
| sda_i | input | 1 | Synchronised bus data (wired level) |
| addr_sel_i | input | 1 | Level compared with address bit 1 |
| sda_oe_o | output | 1 | Pull SDA low (acknowledge) |
| r_div_o | output | 16 | Active reference divide value |
| n_div_o | output | 16 | Active loop divide value |
| status_o | output | 8 | Active control byte |
| band_fm_o | output | 1 | Band select (control bit 0) |
| cp_fast_o | output | 1 | Charge-pump high-current select (control bit 1) |
| sw_port_o | output | 5 | Switching-port bits (control bits 6:2) |

## Verification
Some rules are checked by assertions on every cycle:

- The acknowledge pull-down moves only while SCL is low and is released after any START or STOP.
- The divide values and the control byte change only in the cycle after a STOP.
- The outputs are clear when reset is released.

Other behaviour can only be shown by the bench scenarios. These include address matching against the select pin and the read flag, the byte order of each group, and the discarding of partial, unknown-subaddress, surplus and repeated-START data.

// File: rtl/tuner_pkg.sv
package tuner_pkg;

    localparam int DIV_W   = 16;
    localparam int CTRL_W  = 8;
    localparam int SW_W    = 5;
    localparam int IDX_W   = 3;
    localparam int BITS_W  = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_SUB,
        ST_SUB_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_SKIP
    } bus_state_t;

    typedef enum logic [1:0] {
        GRP_NONE,
        GRP_R,
        GRP_N
    } grp_t;

endpackage

// File: rtl/tuner_bus_edge.sv
module tuner_bus_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    logic scl_q;
    logic sda_q;

    // Idle bus level is high on both lines.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    always_comb begin
        scl_rise_o = !scl_q && scl_i;
        scl_fall_o = scl_q && !scl_i;
        // SDA moving while SCL is held high marks a bus condition.
        start_o    = scl_q && scl_i && sda_q && !sda_i;
        stop_o     = scl_q && scl_i && !sda_q && sda_i;
    end

endmodule

// File: rtl/tuner_bus_fsm.sv
module tuner_bus_fsm
    import tuner_pkg::*;
#(
    parameter logic [5:0] DEV_ADDR_HI = 6'b110001,
    parameter logic [7:0] SUB_R       = 8'h00,
    parameter logic [7:0] SUB_N       = 8'h01
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sda_i,
    input  logic             addr_sel_i,
    input  logic             scl_rise_i,
    input  logic             scl_fall_i,
    input  logic             start_i,
    input  logic             stop_i,
    output logic             sda_oe_o,
    output logic             wr_stb_o,
    output grp_t             wr_grp_o,
    output logic [IDX_W-1:0] wr_idx_o,
    output logic [7:0]       wr_data_o
);

    localparam logic [BITS_W-1:0] BYTE_BITS = BITS_W'(8);
    localparam logic [IDX_W-1:0]  IDX_MAX   = {IDX_W{1'b1}};

    bus_state_t        state_q, state_d;
    logic [BITS_W-1:0] bits_q, bits_d;
    logic [7:0]        shreg_q, shreg_d;
    grp_t              grp_q, grp_d;
    logic [IDX_W-1:0]  idx_q, idx_d;

    logic byte_done;
    logic addr_hit;

    assign byte_done = scl_fall_i && (bits_q == BYTE_BITS);
    assign addr_hit  = (shreg_q[7:2] == DEV_ADDR_HI) &&
                       (shreg_q[1] == addr_sel_i) && !shreg_q[0];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bits_q  <= '0;
            shreg_q <= '0;
            grp_q   <= GRP_NONE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            bits_q  <= bits_d;
            shreg_q <= shreg_d;
            grp_q   <= grp_d;
            idx_q   <= idx_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        bits_d  = bits_q;
        shreg_d = shreg_q;
        grp_d   = grp_q;
        idx_d   = idx_q;
        if (start_i) begin
            state_d = ST_ADDR;
            bits_d  = '0;
            grp_d   = GRP_NONE;
            idx_d   = '0;
        end else if (stop_i) begin
            state_d = ST_IDLE;
            bits_d  = '0;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_SKIP: begin
                end
                ST_ADDR, ST_SUB, ST_DATA: begin
                    if (scl_rise_i) begin
                        shreg_d = {shreg_q[6:0], sda_i};
                        bits_d  = bits_q + 1'b1;
                    end else if (byte_done) begin
                        bits_d = '0;
                        if (state_q == ST_ADDR) begin
                            state_d = addr_hit ? ST_ADDR_ACK : ST_SKIP;
                        end else if (state_q == ST_SUB) begin
                            state_d = ST_SUB_ACK;
                            if (shreg_q == SUB_R)      grp_d = GRP_R;
                            else if (shreg_q == SUB_N) grp_d = GRP_N;
                            else                       grp_d = GRP_NONE;
                        end else begin
                            state_d = ST_DATA_ACK;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall_i) state_d = ST_SUB;
                end
                ST_SUB_ACK: begin
                    if (scl_fall_i) state_d = ST_DATA;
                end
                ST_DATA_ACK: begin
                    if (scl_fall_i) begin
                        state_d = ST_DATA;
                        if (idx_q != IDX_MAX) idx_d = idx_q + 1'b1;
                    end
                end
            endcase
        end
    end

    // Output logic
    always_comb begin
        sda_oe_o  = (state_q == ST_ADDR_ACK) || (state_q == ST_SUB_ACK) ||
                    (state_q == ST_DATA_ACK);
        wr_stb_o  = (state_q == ST_DATA) && byte_done && !start_i &&
                    !stop_i && (grp_q != GRP_NONE);
        wr_grp_o  = grp_q;
        wr_idx_o  = idx_q;
        wr_data_o = shreg_q;
    end

endmodule

// File: rtl/tuner_reg_bank.sv
module tuner_reg_bank
    import tuner_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              wr_stb_i,
    input  grp_t              wr_grp_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [7:0]        wr_data_i,
    output logic [DIV_W-1:0]  r_div_o,
    output logic [DIV_W-1:0]  n_div_o,
    output logic [CTRL_W-1:0] ctrl_o
);

    localparam logic [IDX_W-1:0] R_LAST = IDX_W'(2);
    localparam logic [IDX_W-1:0] N_LAST = IDX_W'(1);

    logic [CTRL_W-1:0] sh_ctrl;
    logic [DIV_W-1:0]  sh_r;
    logic [DIV_W-1:0]  sh_n;
    logic              r_full;
    logic              n_full;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_ctrl <= '0;
            sh_r    <= '0;
            sh_n    <= '0;
            r_full  <= 1'b0;
            n_full  <= 1'b0;
            r_div_o <= '0;
            n_div_o <= '0;
            ctrl_o  <= '0;
        end else if (start_i) begin
            r_full <= 1'b0;
            n_full <= 1'b0;
        end else if (stop_i) begin
            if (r_full) begin
                ctrl_o  <= sh_ctrl;
                r_div_o <= sh_r;
            end
            if (n_full) n_div_o <= sh_n;
            r_full <= 1'b0;
            n_full <= 1'b0;
        end else if (wr_stb_i) begin
            if (wr_grp_i == GRP_R) begin
                case (wr_idx_i)
                    IDX_W'(0): sh_ctrl    <= wr_data_i;
                    IDX_W'(1): sh_r[15:8] <= wr_data_i;
                    R_LAST: begin
                        sh_r[7:0] <= wr_data_i;
                        r_full    <= 1'b1;
                    end
                    default: begin
                    end
                endcase
            end else if (wr_grp_i == GRP_N) begin
                case (wr_idx_i)
                    IDX_W'(0): sh_n[15:8] <= wr_data_i;
                    N_LAST: begin
                        sh_n[7:0] <= wr_data_i;
                        n_full    <= 1'b1;
                    end
                    default: begin
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/tuner_i2c_regs.sv
module tuner_i2c_regs
    import tuner_pkg::*;
#(
    parameter logic [5:0] DEV_ADDR_HI = 6'b110001,
    parameter logic [7:0] SUB_R       = 8'h00,
    parameter logic [7:0] SUB_N       = 8'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              addr_sel_i,
    output logic              sda_oe_o,
    output logic [DIV_W-1:0]  r_div_o,
    output logic [DIV_W-1:0]  n_div_o,
    output logic [CTRL_W-1:0] status_o,
    output logic              band_fm_o,
    output logic              cp_fast_o,
    output logic [SW_W-1:0]   sw_port_o
);

    logic             scl_rise;
    logic             scl_fall;
    logic             start_p;
    logic             stop_p;
    logic             wr_stb;
    grp_t             wr_grp;
    logic [IDX_W-1:0] wr_idx;
    logic [7:0]       wr_data;

    tuner_bus_edge u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_p),
        .stop_o     (stop_p)
    );

    tuner_bus_fsm #(
        .DEV_ADDR_HI (DEV_ADDR_HI),
        .SUB_R       (SUB_R),
        .SUB_N       (SUB_N)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sda_i      (sda_i),
        .addr_sel_i (addr_sel_i),
        .scl_rise_i (scl_rise),
        .scl_fall_i (scl_fall),
        .start_i    (start_p),
        .stop_i     (stop_p),
        .sda_oe_o   (sda_oe_o),
        .wr_stb_o   (wr_stb),
        .wr_grp_o   (wr_grp),
        .wr_idx_o   (wr_idx),
        .wr_data_o  (wr_data)
    );

    tuner_reg_bank u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_p),
        .stop_i    (stop_p),
        .wr_stb_i  (wr_stb),
        .wr_grp_i  (wr_grp),
        .wr_idx_i  (wr_idx),
        .wr_data_i (wr_data),
        .r_div_o   (r_div_o),
        .n_div_o   (n_div_o),
        .ctrl_o    (status_o)
    );

    // Control byte decode (R10)
    assign band_fm_o = status_o[0];
    assign cp_fast_o = status_o[1];
    assign sw_port_o = status_o[2 +: SW_W];

endmodule

// File: rtl/tuner_regs_chk.sv
module tuner_regs_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        scl_i,
    input logic        sda_oe_o,
    input logic        start_p,
    input logic        stop_p,
    input logic [15:0] r_div_o,
    input logic [15:0] n_div_o,
    input logic [7:0]  status_o
);

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (r_div_o == 16'h0 && n_div_o == 16'h0 &&
                          status_o == 8'h0 && !sda_oe_o));

    assert_r_commit_on_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(r_div_o) |-> $past(stop_p));

    assert_n_commit_on_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(n_div_o) |-> $past(stop_p));

    assert_ctrl_commit_on_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(status_o) |-> $past(stop_p));

    assert_ack_rise_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> !scl_i);

    assert_ack_fall_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe_o) |-> !scl_i);

    assert_release_after_cond_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (start_p || stop_p) |=> !sda_oe_o);

endmodule

bind tuner_i2c_regs tuner_regs_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_oe_o (sda_oe_o),
    .start_p  (start_p),
    .stop_p   (stop_p),
    .r_div_o  (r_div_o),
    .n_div_o  (n_div_o),
    .status_o (status_o)
);

// File: tb/test_tuner_i2c_regs.sv
module test_tuner_i2c_regs;

    localparam int CLK_PERIOD = 10;
    localparam int Q          = 6;

    typedef struct {
        logic [15:0] r;
        logic [15:0] n;
        logic [7:0]  st;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_scl = 1'b1;
    logic        m_sda = 1'b1;
    logic        addr_sel = 1'b0;
    logic        bus_sda;
    logic        sda_oe;
    logic [15:0] r_div, n_div;
    logic [7:0]  status;
    logic        band_fm, cp_fast;
    logic [4:0]  sw_port;

    int   total = 0;
    int   bad   = 0;
    bit   done  = 0;
    exp_t exp_q[$];

    logic [15:0] cur_r = 16'h0;
    logic [15:0] cur_n = 16'h0;
    logic [7:0]  cur_st = 8'h0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Wired-AND bus: the slave can only pull low.
    assign bus_sda = m_sda & ~sda_oe;

    tuner_i2c_regs i_tuner_i2c_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (m_scl),
        .sda_i      (bus_sda),
        .addr_sel_i (addr_sel),
        .sda_oe_o   (sda_oe),
        .r_div_o    (r_div),
        .n_div_o    (n_div),
        .status_o   (status),
        .band_fm_o  (band_fm),
        .cp_fast_o  (cp_fast),
        .sw_port_o  (sw_port)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; hold(Q);
        m_scl = 1'b1; hold(Q);
        m_sda = 1'b0; hold(Q);
        m_scl = 1'b0; hold(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; hold(Q);
        m_scl = 1'b1; hold(Q);
        m_sda = 1'b1; hold(2*Q);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic exp_ack,
                             input string tag);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; hold(Q);
            m_scl = 1'b1; hold(2*Q);
            m_scl = 1'b0; hold(Q);
        end
        m_sda = 1'b1; hold(Q);
        m_scl = 1'b1; hold(Q);
        chk(tag, "ack", {31'h0, sda_oe}, {31'h0, exp_ack});
        hold(Q);
        m_scl = 1'b0; hold(Q);
    endtask

    // Driver: one transfer; data bytes after the subaddress.
    task automatic xfer(input logic [7:0] addr, input logic [7:0] sub,
                        input logic [7:0] d0, input logic [7:0] d1,
                        input logic [7:0] d2, input int cnt,
                        input logic exp_ack, input bit do_stop,
                        input string tag);
        logic [7:0] d [3];
        d[0] = d0; d[1] = d1; d[2] = d2;
        bus_start();
        send_byte(addr, exp_ack, tag);
        send_byte(sub, exp_ack, tag);
        for (int k = 0; k < cnt; k++) send_byte(d[k], exp_ack, tag);
        if (do_stop) bus_stop();
    endtask

    task automatic push_exp(input string tag);
        exp_t e;
        e.r = cur_r; e.n = cur_n; e.st = cur_st; e.tag = tag;
        exp_q.push_back(e);
        wait (exp_q.size() == 0);
        hold(2);
    endtask

    // Monitor: pops expected output sets and compares them.
    initial begin
        forever begin
            exp_t e;
            wait (exp_q.size() != 0);
            hold(3);
            e = exp_q[0];
            chk(e.tag, "r_div", {16'h0, r_div}, {16'h0, e.r});
            chk(e.tag, "n_div", {16'h0, n_div}, {16'h0, e.n});
            chk(e.tag, "status", {24'h0, status}, {24'h0, e.st});
            // R10 decode of the control byte
            chk("R10", "band", {31'h0, band_fm}, {31'h0, e.st[0]});
            chk("R10", "cp", {31'h0, cp_fast}, {31'h0, e.st[1]});
            chk("R10", "sw", {27'h0, sw_port}, {27'h0, e.st[6:2]});
            void'(exp_q.pop_front());
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog act=timeout exp=finish");
        finish_run();
    end

    initial begin
        hold(4);
        // R1: reset state
        chk("R1", "sda_oe", {31'h0, sda_oe}, 32'h0);
        rst_n = 1'b1;
        hold(2);
        push_exp("R1");

        // R2/R4: reference group with select low, address 0xC4
        xfer(8'hC4, 8'h00, 8'h6D, 8'h12, 8'h34, 3, 1'b1, 1, "R4");
        cur_st = 8'h6D; cur_r = 16'h1234;
        push_exp("R4");

        // R5: loop group
        xfer(8'hC4, 8'h01, 8'hBE, 8'hEF, 8'h00, 2, 1'b1, 1, "R5");
        cur_n = 16'hBEEF;
        push_exp("R5");

        // R3: address bit 1 disagrees with the select pin
        xfer(8'hC6, 8'h00, 8'h11, 8'h22, 8'h33, 3, 1'b0, 1, "R3");
        push_exp("R3");

        // R2: select high, address 0xC6 accepted
        addr_sel = 1'b1;
        hold(2);
        xfer(8'hC6, 8'h01, 8'h04, 8'h00, 8'h00, 2, 1'b1, 1, "R2");
        cur_n = 16'h0400;
        push_exp("R2");

        // R3: 0xC4 now mismatches, read flag set, wrong upper bits
        xfer(8'hC4, 8'h01, 8'h77, 8'h77, 8'h00, 2, 1'b0, 1, "R3");
        push_exp("R3");
        xfer(8'hC7, 8'h01, 8'h77, 8'h77, 8'h00, 2, 1'b0, 1, "R3");
        push_exp("R3");
        xfer(8'h46, 8'h00, 8'h77, 8'h77, 8'h77, 3, 1'b0, 1, "R3");
        push_exp("R3");

        // R7: unknown subaddress acknowledged, data ignored
        xfer(8'hC6, 8'h05, 8'h01, 8'h02, 8'h03, 3, 1'b1, 1, "R7");
        push_exp("R7");

        // R6: partial reference group changes nothing
        xfer(8'hC6, 8'h00, 8'h02, 8'h99, 8'h00, 2, 1'b1, 1, "R6");
        push_exp("R6");

        // R9: complete reference group, then repeated START with loop group
        xfer(8'hC6, 8'h00, 8'h7F, 8'hAB, 8'hCD, 3, 1'b1, 0, "R9");
        xfer(8'hC6, 8'h01, 8'h12, 8'h34, 8'h00, 2, 1'b1, 1, "R9");
        cur_n = 16'h1234;
        push_exp("R9");

        // R8: surplus byte acknowledged and ignored
        xfer(8'hC6, 8'h01, 8'h55, 8'h66, 8'h77, 3, 1'b1, 1, "R8");
        cur_n = 16'h5566;
        push_exp("R8");

        // R6/R10: reference group write leaves the loop value alone
        xfer(8'hC6, 8'h00, 8'h82, 8'hFF, 8'hFF, 3, 1'b1, 1, "R6");
        cur_st = 8'h82; cur_r = 16'hFFFF;
        push_exp("R6");

        // R6: loop group with a single byte
        xfer(8'hC6, 8'h01, 8'hAA, 8'h00, 8'h00, 1, 1'b1, 1, "R6");
        push_exp("R6");

        // R11: bus released after STOP
        chk("R11", "sda_oe idle", {31'h0, sda_oe}, 32'h0);

        finish_run();
    end

endmodule